// File: doc/BRIEF.md
# Shadowed On/Off-Count PWM Controller

A single-channel pulse-width modulator on a plain memory-mapped register bus. Software programs the waveform as two cycle counts: how many clock cycles the output spends high and how many it then spends low. The pattern repeats for as long as the channel runs. One period lasts the sum of the two counts.

Writes to the two count registers land in shadow copies and do not disturb the running waveform. The new counts move into the active counters only when software writes the control register with its load bit set. The waveform then restarts at the start of its high phase. The output drives a level only when both the run bit and the drive bit of the control register are set. Otherwise it is held low. An invert bit flips the level while the channel is driving.

Top module: `shadow_pwm`

## Requirements
- R1: After reset the control register and both count registers read zero and `pwmOut` is low.
- R2: The register map is control at byte offset 0x00, low-count at 0x18 and high-count at 0x1C. The count registers read back the last value written to them. Control keeps only bits 0, 2, 9, 10 and 14, and all other control bits read zero. Any other offset reads zero.
- R3: A write to a count register does not change the waveform until the control register is written with bit 5 set.
- R4: Control bit 5 is a load strobe that always reads zero. A control write with bit 5 clear loads no new counts.
- R5: With active high-count H and low-count L, both nonzero, and the channel driving, the output is high for H cycles and then low for L cycles, repeating. The high phase starts in the first cycle after the loading write.
- R6: The output is low unless control bit 0 (run) and bit 14 (drive) are both set. While either bit is clear, the phase restarts, so driving resumes at the start of the high phase.
- R7: With control bit 10 set, the driven waveform is inverted.
- R8: When both active counts are zero, the output is low, even when bit 10 is set.
- R9: When only the high-count is zero, the output is held low, or high if inverted. When only the low-count is zero, the output is held high, or low if inverted.
- R10: Loading counts while a period is in progress restarts the waveform at the beginning of its high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W (8) | Byte offset for reads and writes |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | DATA_W (32) | Write data |
| busRdData | output | DATA_W (32) | Read data for `busAddr`, combinational |
| pwmOut | output | 1 | PWM output |

## Verification
The assertions assume that the bus presents at most one write per cycle. They also assume that the address is stable while the write strobe is high, and that the count width does not exceed the data width. The bench drives every write as a single-cycle strobe in a clean cycle, with addresses taken only from the register map or from one deliberately unmapped offset. Waveform windows are sampled on falling edges after the loading write, so the phase-restart properties line up with the cycle the bench samples.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned OFF_CTRL = 32'h00;
  localparam int unsigned OFF_LOW  = 32'h18;
  localparam int unsigned OFF_HIGH = 32'h1C;

  localparam int BIT_RUN    = 0;
  localparam int BIT_RSVA   = 2;
  localparam int BIT_LOAD   = 5;
  localparam int BIT_RSVB   = 9;
  localparam int BIT_INVERT = 10;
  localparam int BIT_DRIVE  = 14;

  typedef struct packed {
    logic loadCnt;
    logic run;
    logic invert;
  } ctrlStrobe_t;
endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic [CNT_W-1:0]  shadowHigh,
  output logic [CNT_W-1:0]  shadowLow,
  output ctrlStrobe_t       strobe
);
  localparam logic [DATA_W-1:0] KEEP_MASK =
    (DATA_W'(1) << BIT_RUN) | (DATA_W'(1) << BIT_RSVA) | (DATA_W'(1) << BIT_RSVB) |
    (DATA_W'(1) << BIT_INVERT) | (DATA_W'(1) << BIT_DRIVE);

  logic [DATA_W-1:0] ctrlReg;
  logic hitCtrl, hitLow, hitHigh;

  assign hitCtrl = (busAddr == ADDR_W'(OFF_CTRL));
  assign hitLow  = (busAddr == ADDR_W'(OFF_LOW));
  assign hitHigh = (busAddr == ADDR_W'(OFF_HIGH));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg    <= '0;
      shadowHigh <= '0;
      shadowLow  <= '0;
    end else if (busWrEn) begin
      if (hitCtrl) ctrlReg    <= busWrData & KEEP_MASK;
      if (hitLow)  shadowLow  <= busWrData[CNT_W-1:0];
      if (hitHigh) shadowHigh <= busWrData[CNT_W-1:0];
    end
  end

  always_comb begin
    busRdData = '0;
    if (hitCtrl)      busRdData = ctrlReg;
    else if (hitLow)  busRdData = DATA_W'(shadowLow);
    else if (hitHigh) busRdData = DATA_W'(shadowHigh);
  end

  assign strobe.loadCnt = busWrEn && hitCtrl && busWrData[BIT_LOAD];
  assign strobe.run     = ctrlReg[BIT_RUN] && ctrlReg[BIT_DRIVE];
  assign strobe.invert  = ctrlReg[BIT_INVERT];

  // R3
  count_write_keeps_ctrl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && (hitLow || hitHigh)) |=> $stable(ctrlReg));

  // R2
  shadow_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && hitHigh) |=> (shadowHigh == $past(busWrData[CNT_W-1:0])));
endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import pwm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [CNT_W-1:0] shadowHigh,
  input  logic [CNT_W-1:0] shadowLow,
  output logic             pwmOut
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] highAct, lowAct, phaseCnt;
  logic phaseHigh;
  logic highZero, lowZero, degenerate, rawLevel;

  assign highZero   = (highAct == '0);
  assign lowZero    = (lowAct == '0);
  assign degenerate = highZero || lowZero;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      highAct   <= '0;
      lowAct    <= '0;
      phaseCnt  <= '0;
      phaseHigh <= 1'b1;
    end else if (strobe.loadCnt) begin
      highAct   <= shadowHigh;
      lowAct    <= shadowLow;
      phaseCnt  <= '0;
      phaseHigh <= 1'b1;
    end else if (!strobe.run || degenerate) begin
      phaseCnt  <= '0;
      phaseHigh <= 1'b1;
    end else if (phaseHigh) begin
      if (phaseCnt == highAct - ONE) begin
        phaseCnt  <= '0;
        phaseHigh <= 1'b0;
      end else begin
        phaseCnt <= phaseCnt + ONE;
      end
    end else begin
      if (phaseCnt == lowAct - ONE) begin
        phaseCnt  <= '0;
        phaseHigh <= 1'b1;
      end else begin
        phaseCnt <= phaseCnt + ONE;
      end
    end
  end

  always_comb begin
    if (highZero)     rawLevel = 1'b0;
    else if (lowZero) rawLevel = 1'b1;
    else              rawLevel = phaseHigh;
  end

  assign pwmOut = strobe.run && !(highZero && lowZero) && (rawLevel ^ strobe.invert);

  // R10
  restart_on_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadCnt |=> (phaseHigh && phaseCnt == '0));

  // R3
  active_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadCnt |=> ($stable(highAct) && $stable(lowAct)));

  // R3
  active_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadCnt |=> (highAct == $past(shadowHigh) && lowAct == $past(shadowLow)));

  // R5
  high_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phaseHigh && !degenerate) |-> (phaseCnt < highAct));

  // R5
  low_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!phaseHigh && !degenerate) |-> (phaseCnt < lowAct));

  // R6
  gate_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.run |-> !pwmOut);
endmodule

// File: rtl/shadow_pwm.sv
module shadow_pwm
  import pwm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              pwmOut
);
  ctrlStrobe_t      strobe;
  logic [CNT_W-1:0] shadowHigh, shadowLow;

  pwm_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData),
    .shadowHigh(shadowHigh), .shadowLow(shadowLow), .strobe(strobe)
  );

  pwm_datapath #(.CNT_W(CNT_W)) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .shadowHigh(shadowHigh), .shadowLow(shadowLow), .pwmOut(pwmOut)
  );
endmodule

// File: tb/test_shadow_pwm.sv
module test_shadow_pwm;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        pwmOut;

  int total = 0;
  int bad = 0;

  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_LOW  = 8'h18;
  localparam logic [7:0] A_HIGH = 8'h1C;
  localparam logic [31:0] GO     = 32'h4021;
  localparam logic [31:0] GO_INV = 32'h4421;

  shadow_pwm i_shadow_pwm (.*);

  always #5 clk = ~clk;

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog: run did not finish (got timeout, expected completion)");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk);
    #1 busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic wave(input string req, input int n, input logic [31:0] exp);
    logic [31:0] got = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      got = {got[30:0], pwmOut};
    end
    check(req, got, exp);
  endtask

  task automatic countHigh(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwmOut) c++;
    end
  endtask

  task automatic load(input logic [31:0] h, input logic [31:0] l, input logic [31:0] c);
    wr(A_HIGH, h);
    wr(A_LOW, l);
    wr(A_CTRL, c);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(A_CTRL, d); check("R1 ctrl", d, 0);
    rd(A_LOW, d);  check("R1 low", d, 0);
    rd(A_HIGH, d); check("R1 high", d, 0);
    check("R1 out", {31'b0, pwmOut}, 0);
  endtask

  task automatic t_regmap;
    logic [31:0] d;
    wr(A_HIGH, 32'd5);
    wr(A_LOW, 32'd7);
    rd(A_HIGH, d); check("R2 high readback", d, 5);
    rd(A_LOW, d);  check("R2 low readback", d, 7);
    wr(A_CTRL, 32'hFFFF_FFDF);
    rd(A_CTRL, d); check("R2 ctrl kept bits", d, 32'h4605);
    rd(8'h04, d);  check("R2 unmapped", d, 0);
    wr(A_CTRL, 32'h0);
    wr(A_CTRL, 32'h0000_0020);
    rd(A_CTRL, d); check("R4 load bit reads zero", d, 0);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_basic;
    logic [31:0] d;
    load(3, 2, GO);
    wave("R5 3/2 wave", 10, 32'b1110011100);
    rd(A_CTRL, d); check("R4 ctrl after load", d, 32'h4001);
  endtask

  task automatic t_shadow;
    int c;
    wr(A_HIGH, 1);
    wr(A_LOW, 1);
    countHigh(10, c); check("R3 shadow hidden", c, 6);
    wr(A_CTRL, 32'h4001);
    countHigh(10, c); check("R4 no load without bit5", c, 6);
    wr(A_CTRL, GO);
    wave("R3 new counts after load", 10, 32'b1010101010);
  endtask

  task automatic t_restart;
    load(4, 4, GO);
    @(negedge clk); @(negedge clk);
    wr(A_CTRL, GO);
    wave("R10 restart mid period", 8, 32'b11110000);
  endtask

  task automatic t_gate;
    load(2, 2, GO);
    wr(A_CTRL, 32'h0001);
    wave("R6 run only", 8, 32'b0);
    wr(A_CTRL, 32'h4000);
    wave("R6 drive only", 8, 32'b0);
    wr(A_CTRL, 32'h0);
    wave("R6 ctrl zero", 8, 32'b0);
    wr(A_CTRL, 32'h4001);
    wave("R6 resume at high phase", 8, 32'b11001100);
  endtask

  task automatic t_invert;
    load(2, 3, GO_INV);
    wave("R7 inverted", 10, 32'b0011100111);
  endtask

  task automatic t_degen;
    load(0, 0, GO);
    wave("R8 both zero", 8, 32'b0);
    wr(A_CTRL, GO_INV);
    wave("R8 both zero inverted", 8, 32'b0);
    load(0, 5, GO);
    wave("R9 high zero", 8, 32'b0);
    wr(A_CTRL, GO_INV);
    wave("R9 high zero inverted", 8, 32'hFF);
    load(4, 0, GO);
    wave("R9 low zero", 8, 32'hFF);
    wr(A_CTRL, GO_INV);
    wave("R9 low zero inverted", 8, 32'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    t_reset();
    t_regmap();
    t_basic();
    t_shadow();
    t_restart();
    t_gate();
    t_invert();
    t_degen();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule